// File: doc/BRIEF.md
# Sleep State Power Controller

This block tracks the platform power state and drives the power-plane enables that go with it. It reports one of five states (S0 working, S1 standby, S3 suspend to RAM, S4 suspend to disk, S5 soft off). It drives three active-low plane-off outputs, one for each of the S3, S4 and S5 levels. The plane outputs are nested: each deeper state also keeps every shallower plane switched off.

Firmware asks for a low-power state with a one-cycle request that carries the target state code. Before any plane is switched off, the block asserts a suspend-status output and holds it for a programmable number of slow ticks, so that attached devices can isolate their outputs first. On wake, the planes come back one per tick from the deepest level upward. Suspend status drops one tick after the last plane is back.

Wake sources are a press of the debounced power button and a ring-indicate input. The ring input counts only when its enable bit is set, and that bit is supplied from always-on storage. A button press while working does not change state; it raises a one-cycle sleep-request flag toward firmware instead. A button held past the override time, or a low thermal-trip input, forces soft off at once and skips the lead time.

Top module: `sleep_seq`

## Requirements
- R1: After reset the state output reads 0 (S0), all three plane outputs are high, suspend status is low and the sleep-request flag is low.
- R2: The state output codes are S0=0, S1=1, S3=3, S4=4, S5=5, and the plane outputs follow that state. `s3_off_n` is low in S3, S4 and S5. `s4_off_n` is low in S4 and S5. `s5_off_n` is low only in S5. In S1 all three are high.
- R3: A `sleep_req` pulse in S0 with a target of 1, 3, 4 or 5 asserts suspend status on the next cycle. The state and planes stay unchanged for `SETUP_TICKS` ticks and take the target on the `SETUP_TICKS`-th tick. Target codes 0, 2, 6 and 7 are ignored.
- R4: A rising edge of `btn_down` while the state reads S0 pulses `sleep_irq` high for exactly one cycle and leaves the state at S0.
- R5: A rising edge of `btn_down` in a sleep state starts a wake. On each following tick one plane level is released, in the order S5, S4, S3. On the tick after all planes are high, the state returns to 0 and suspend status drops.
- R6: A high `ring_in` in a sleep state wakes the block as in R5 only when `ring_wake_en` is 1. With the enable at 0 it has no effect.
- R7: If `btn_down` is held through more than `OVR_TICKS` ticks, the block goes to S5, with suspend status high and all planes low, on tick `OVR_TICKS`+1, from any state. Releasing the button clears the count.
- R8: While `trip_n` is low, the state reads S5 from the next cycle on, with all planes low. Wake events are ignored for as long as `trip_n` stays low.
- R9: Suspend status is high whenever any plane output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Slow-time clock enable, one cycle wide |
| btn_down | input | 1 | Debounced power button, high while pressed |
| ring_in | input | 1 | Ring-indicate wake input, active high |
| ring_wake_en | input | 1 | Ring wake enable from always-on storage |
| trip_n | input | 1 | Thermal trip, active low |
| sleep_req | input | 1 | One-cycle software sleep request |
| sleep_target | input | 3 | Target state code for sleep_req |
| sleep_irq | output | 1 | One-cycle sleep-request flag to firmware |
| susp_stat | output | 1 | Suspend status, high before and during low power |
| s3_off_n | output | 1 | S3-level plane off, active low |
| s4_off_n | output | 1 | S4-level plane off, active low |
| s5_off_n | output | 1 | S5-level plane off, active low |
| state_o | output | 3 | Current power state code |

## Verification
The bench builds the block with `SETUP_TICKS` = 3 and `OVR_TICKS` = 20, and it issues a tick every fourth clock. With these values the four-second button override fires within a few hundred cycles, so the bench can check its exact threshold several times. This includes a hold of exactly `OVR_TICKS` ticks followed by a release, and a hold that starts inside a sleep state. A lead time of three ticks keeps the entry window long enough to check that the planes hold their values until the final tick. Random sleep and wake cycles run across all four targets, using both wake sources.

// File: rtl/sleep_pkg.sv
package sleep_pkg;
    typedef enum logic [1:0] {PH_ON, PH_ENTER, PH_SLEEP, PH_EXIT} phase_e;

    localparam logic [2:0] PS_S0 = 3'd0;
    localparam logic [2:0] PS_S1 = 3'd1;
    localparam logic [2:0] PS_S3 = 3'd3;
    localparam logic [2:0] PS_S4 = 3'd4;
    localparam logic [2:0] PS_S5 = 3'd5;

    // only these codes may be requested by software
    function automatic logic target_ok(logic [2:0] t);
        return (t == PS_S1) || (t == PS_S3) || (t == PS_S4) || (t == PS_S5);
    endfunction

    // number of nested planes switched off for a state
    function automatic logic [1:0] depth_of(logic [2:0] t);
        case (t)
            PS_S3:   return 2'd1;
            PS_S4:   return 2'd2;
            PS_S5:   return 2'd3;
            default: return 2'd0;
        endcase
    endfunction
endpackage

// File: rtl/sleep_btn_mon.sv
module sleep_btn_mon #(
    parameter int OVR_TICKS = 131072
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic btn_down,
    output logic press_o,
    output logic override_o
);
    localparam int CW = $clog2(OVR_TICKS + 2);
    localparam logic [CW-1:0] LIMIT = CW'(OVR_TICKS);

    typedef struct packed {
        logic          btn;
        logic [CW-1:0] cnt;
    } mon_t;

    mon_t mon_d, mon_q;

    always_comb begin
        mon_d     = mon_q;
        mon_d.btn = btn_down;
        if (!btn_down) begin
            mon_d.cnt = '0;
        end else if (tick && (mon_q.cnt <= LIMIT)) begin
            mon_d.cnt = mon_q.cnt + 1'b1;
        end
    end

    assign press_o    = btn_down && !mon_q.btn;
    assign override_o = btn_down && tick && (mon_q.cnt == LIMIT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mon_q <= '0;
        end else begin
            mon_q <= mon_d;
        end
    end
endmodule

// File: rtl/sleep_plane_drv.sv
module sleep_plane_drv #(
    parameter int NPL = 3,
    parameter int LW  = 2
) (
    input  logic [LW-1:0]  depth,
    output logic [NPL-1:0] off_n
);
    for (genvar g = 0; g < NPL; g++) begin : g_plane
        assign off_n[g] = !(depth > LW'(g));
    end
endmodule

// File: rtl/sleep_seq.sv
module sleep_seq #(
    parameter int SETUP_TICKS = 4,
    parameter int OVR_TICKS   = 131072
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       btn_down,
    input  logic       ring_in,
    input  logic       ring_wake_en,
    input  logic       trip_n,
    input  logic       sleep_req,
    input  logic [2:0] sleep_target,
    output logic       sleep_irq,
    output logic       susp_stat,
    output logic       s3_off_n,
    output logic       s4_off_n,
    output logic       s5_off_n,
    output logic [2:0] state_o
);
    import sleep_pkg::*;

    localparam int NPL = 3;
    localparam int LW  = $clog2(NPL + 1);
    localparam int SW  = $clog2(SETUP_TICKS + 1);
    localparam logic [SW-1:0] SETUP_LAST = SW'(SETUP_TICKS - 1);

    typedef struct packed {
        phase_e        phase;
        logic [2:0]    pstate;
        logic [2:0]    target;
        logic [LW-1:0] depth;
        logic          susp;
        logic          irq;
        logic [SW-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;
    logic press, ovr, wake;
    logic [NPL-1:0] planes_n;

    sleep_btn_mon #(.OVR_TICKS(OVR_TICKS)) btn_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .btn_down   (btn_down),
        .press_o    (press),
        .override_o (ovr)
    );

    assign wake = press || (ring_in && ring_wake_en);

    always_comb begin
        seq_d     = seq_q;
        seq_d.irq = 1'b0;
        case (seq_q.phase)
            PH_ON: begin
                if (press) seq_d.irq = 1'b1;
                if (sleep_req && target_ok(sleep_target)) begin
                    seq_d.phase  = PH_ENTER;
                    seq_d.target = sleep_target;
                    seq_d.susp   = 1'b1;
                    seq_d.cnt    = '0;
                end
            end
            PH_ENTER: begin
                if (press) seq_d.irq = 1'b1;
                if (tick) begin
                    if (seq_q.cnt == SETUP_LAST) begin
                        seq_d.phase  = PH_SLEEP;
                        seq_d.pstate = seq_q.target;
                        seq_d.depth  = LW'(depth_of(seq_q.target));
                    end else begin
                        seq_d.cnt = seq_q.cnt + 1'b1;
                    end
                end
            end
            PH_SLEEP: begin
                if (wake) seq_d.phase = PH_EXIT;
            end
            PH_EXIT: begin
                if (tick) begin
                    if (seq_q.depth != '0) begin
                        seq_d.depth = seq_q.depth - 1'b1;
                    end else begin
                        seq_d.phase  = PH_ON;
                        seq_d.pstate = PS_S0;
                        seq_d.susp   = 1'b0;
                    end
                end
            end
            default: seq_d.phase = PH_ON;
        endcase
        // forced soft off: no lead time, no handshake
        if (!trip_n || ovr) begin
            seq_d.phase  = PH_SLEEP;
            seq_d.pstate = PS_S5;
            seq_d.target = PS_S5;
            seq_d.depth  = LW'(NPL);
            seq_d.susp   = 1'b1;
            seq_d.irq    = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{phase: PH_ON, pstate: PS_S0, target: PS_S0,
                       depth: '0, susp: 1'b0, irq: 1'b0, cnt: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    sleep_plane_drv #(.NPL(NPL), .LW(LW)) plane_i (
        .depth (seq_q.depth),
        .off_n (planes_n)
    );

    assign s3_off_n  = planes_n[0];
    assign s4_off_n  = planes_n[1];
    assign s5_off_n  = planes_n[2];
    assign susp_stat = seq_q.susp;
    assign sleep_irq = seq_q.irq;
    assign state_o   = seq_q.pstate;
endmodule

// File: rtl/sleep_seq_chk.sv
module sleep_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       trip_n,
    input logic       sleep_irq,
    input logic       susp_stat,
    input logic       s3_off_n,
    input logic       s4_off_n,
    input logic       s5_off_n,
    input logic [2:0] state_o
);
    p_susp_covers_planes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!s3_off_n || !s4_off_n || !s5_off_n) |-> susp_stat);

    p_trip_forces_s5_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !trip_n |=> (state_o == 3'd5) && !s5_off_n);

    p_irq_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_irq |=> !sleep_irq);

    p_irq_in_s0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_irq |-> (state_o == 3'd0));

    p_susp_drop_after_planes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(susp_stat) |-> ($past(s3_off_n) && s3_off_n && state_o == 3'd0));
endmodule

bind sleep_seq sleep_seq_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .trip_n    (trip_n),
    .sleep_irq (sleep_irq),
    .susp_stat (susp_stat),
    .s3_off_n  (s3_off_n),
    .s4_off_n  (s4_off_n),
    .s5_off_n  (s5_off_n),
    .state_o   (state_o)
);

// File: tb/sleep_seq_tb_top.sv
`timescale 1ns/1ps
module sleep_seq_tb_top;
    localparam int SETUP = 3;
    localparam int OVR   = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic btn_down = 1'b0, ring_in = 1'b0, ring_wake_en = 1'b0, trip_n = 1'b1;
    logic sleep_req = 1'b0;
    logic [2:0] sleep_target = 3'd0;
    logic sleep_irq, susp_stat, s3_off_n, s4_off_n, s5_off_n;
    logic [2:0] state_o;

    int checks = 0;
    int fails  = 0;
    int tdiv   = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    always @(negedge clk) begin
        tdiv = (tdiv + 1) % 4;
        tick = (tdiv == 0);
    end

    sleep_seq #(.SETUP_TICKS(SETUP), .OVR_TICKS(OVR)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .btn_down(btn_down),
        .ring_in(ring_in), .ring_wake_en(ring_wake_en), .trip_n(trip_n),
        .sleep_req(sleep_req), .sleep_target(sleep_target),
        .sleep_irq(sleep_irq), .susp_stat(susp_stat), .s3_off_n(s3_off_n),
        .s4_off_n(s4_off_n), .s5_off_n(s5_off_n), .state_o(state_o)
    );

    function automatic int level_of(int st);
        case (st)
            3: return 1;
            4: return 2;
            5: return 3;
            default: return 0;
        endcase
    endfunction

    // {s5,s4,s3} expected for a number of planes switched off
    function automatic logic [2:0] planes_for(int lvl);
        return {lvl < 3, lvl < 2, lvl < 1};
    endfunction

    function automatic logic [2:0] planes_now();
        return {s5_off_n, s4_off_n, s3_off_n};
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            while (!tick) @(posedge clk);
        end
        @(negedge clk);
    endtask

    task automatic request(int tgt);
        @(negedge clk);
        sleep_req = 1'b1;
        sleep_target = 3'(tgt);
        @(negedge clk);
        sleep_req = 1'b0;
    endtask

    task automatic go_sleep(int tgt);
        request(tgt);
        check("R3 susp on request", int'(susp_stat), 1);
        wait_ticks(SETUP - 1);
        check("R3 planes held during lead", int'(planes_now()), 3'b111);
        check("R3 state held during lead", int'(state_o), 0);
        wait_ticks(1);
        check("R2 state after entry", int'(state_o), tgt);
        check("R2 planes after entry", int'(planes_now()), int'(planes_for(level_of(tgt))));
    endtask

    task automatic tap_button();
        @(negedge clk);
        btn_down = 1'b1;
        @(negedge clk);
        btn_down = 1'b0;
    endtask

    task automatic follow_exit(int tgt, string req);
        for (int l = level_of(tgt); l > 0; l--) begin
            wait_ticks(1);
            check({req, " plane release order"}, int'(planes_now()), int'(planes_for(l - 1)));
            check({req, " susp kept during release"}, int'(susp_stat), 1);
        end
        wait_ticks(1);
        check({req, " back to S0"}, int'(state_o), 0);
        check({req, " susp dropped"}, int'(susp_stat), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual 0 expected 1 (run completed)");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h5eed);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        check("R1 state", int'(state_o), 0);
        check("R1 planes", int'(planes_now()), 3'b111);
        check("R1 susp", int'(susp_stat), 0);
        check("R1 irq", int'(sleep_irq), 0);

        // R3 invalid target ignored
        request(2);
        check("R3 invalid target no susp", int'(susp_stat), 0);
        wait_ticks(SETUP + 1);
        check("R3 invalid target state", int'(state_o), 0);

        // R4 press in S0 gives one-cycle flag
        tap_button();
        check("R4 irq raised", int'(sleep_irq), 1);
        @(negedge clk);
        check("R4 irq one cycle", int'(sleep_irq), 0);
        check("R4 state unchanged", int'(state_o), 0);

        // R5 wake from S3 and from S5 by button
        go_sleep(3);
        tap_button();
        check("R5 wake not immediate", int'(state_o), 3);
        follow_exit(3, "R5");
        go_sleep(5);
        tap_button();
        follow_exit(5, "R5");

        // R6 ring wake gated by enable
        go_sleep(1);
        ring_wake_en = 1'b0;
        @(negedge clk) ring_in = 1'b1;
        wait_ticks(4);
        check("R6 disabled ring ignored", int'(state_o), 1);
        ring_in = 1'b0;
        ring_wake_en = 1'b1;
        @(negedge clk) ring_in = 1'b1;
        @(negedge clk) ring_in = 1'b0;
        follow_exit(1, "R6");

        // R7 count clears on release
        @(negedge clk) btn_down = 1'b1;
        wait_ticks(OVR);
        btn_down = 1'b0;
        @(negedge clk) btn_down = 1'b1;
        wait_ticks(OVR);
        check("R7 released hold not accumulated", int'(state_o), 0);
        btn_down = 1'b0;
        // R7 threshold from S0
        @(negedge clk) btn_down = 1'b1;
        wait_ticks(OVR);
        check("R7 no override at limit", int'(state_o), 0);
        wait_ticks(1);
        check("R7 override to S5", int'(state_o), 5);
        check("R7 planes off", int'(planes_now()), 3'b000);
        check("R7 susp on", int'(susp_stat), 1);
        btn_down = 1'b0;
        tap_button();
        follow_exit(5, "R7 wake");
        // R7 hold starting inside S4
        go_sleep(4);
        @(negedge clk) btn_down = 1'b1;
        wait_ticks(OVR);
        check("R7 hold from S4 woke first", int'(state_o), 0);
        wait_ticks(1);
        check("R7 override from S4", int'(state_o), 5);
        btn_down = 1'b0;
        tap_button();
        follow_exit(5, "R7 wake");

        // R8 thermal trip
        @(negedge clk) trip_n = 1'b0;
        @(negedge clk);
        check("R8 trip state", int'(state_o), 5);
        check("R8 trip planes", int'(planes_now()), 3'b000);
        check("R9 susp with planes off", int'(susp_stat), 1);
        tap_button();
        ring_in = 1'b1;
        wait_ticks(6);
        ring_in = 1'b0;
        check("R8 wake ignored during trip", int'(state_o), 5);
        trip_n = 1'b1;
        wait_ticks(2);
        check("R8 stays S5 after trip clears", int'(state_o), 5);
        tap_button();
        follow_exit(5, "R8 wake");

        // random sleep / wake rounds (R2, R3, R5, R6)
        for (int k = 0; k < 30; k++) begin
            int pick, tgt;
            pick = int'($urandom % 4);
            tgt = (pick == 0) ? 1 : pick + 2;
            go_sleep(tgt);
            wait_ticks(int'($urandom % 3));
            check("R2 random sleep state", int'(state_o), tgt);
            if ($urandom % 2 == 0) begin
                tap_button();
                follow_exit(tgt, "R5 random");
            end else begin
                @(negedge clk) ring_in = 1'b1;
                @(negedge clk) ring_in = 1'b0;
                follow_exit(tgt, "R6 random");
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule